// File: doc/BRIEF.md
# Instruction-Rate LED Chaser

This block turns the processor's opcode-fetch activity into a visible speed gauge. A single lit point travels around a bank of eight LEDs. It steps forward one place each time a fixed number of opcode fetches has been seen, so the faster the processor runs, the faster the point circles. Every fetch cycle counts, including each opcode byte of a multi-byte instruction, so the gauge reads slightly above the true instruction rate.

When the clock prescaler is set very slow, waiting for tens of thousands of fetches would leave the point frozen. In that range the point instead steps on every single fetch. LED 0 is never used by the running point. It carries a flag that marks when the boot firmware owns the processor.

All pins are plain control and status signals. There is no data stream and so no valid/ready handshake. The fetch strobe is a level signal from the processor's clock domain, already synchronous to `clk`.

Top module: `fetch_rate_chaser`

## Requirements
- R1: While `rst_n` is low, and after it is released, the fetch counter is zero, the position is 0 and `led[7:1]` are all off.
- R2: A fetch is counted once, on the first `clk` edge at which `m1_active` is sampled high after having been sampled low. Holding `m1_active` high for further cycles adds nothing.
- R3: While `prescale` is below 24'h0FFFFF, the position advances by one on the fetch that completes a group of FETCHES_PER_STEP fetches (default 62,500, so 500,000 fetches make one revolution).
- R4: When the position advances, the fetch counter returns to zero, so the next group again needs a full FETCHES_PER_STEP fetches.
- R5: While `prescale` is 24'h0FFFFF or above (up to 24'hFFFFFF), every counted fetch advances the position.
- R6: The position is a 3-bit value that steps by exactly one and wraps from 7 to 0. It never changes without a counted fetch.
- R7: For positions 1 to 7, `led[k]` is high exactly when the position equals k. At position 0, `led[7:1]` are all off. At most one of `led[7:1]` is ever lit.
- R8: `led[0]` follows `boot_ctx` at all times and has no effect on the position or the count.
- R9: The LED change caused by a fetch appears right after the same `clk` edge at which that fetch is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_active | input | 1 | High during an opcode-fetch cycle |
| prescale | input | 24 | Current clock prescaler setting |
| boot_ctx | input | 1 | Boot firmware active flag |
| led | output | 8 | bit 0: context flag; bits 7..1: running point |

## Verification
Some properties are checked by the assertions on every cycle. The fetch counter always stays below its limit. The position either holds or steps by exactly one, and it moves only on a counted fetch. A slow-mode fetch always steps it. No more than one running-point LED is lit. Other behaviours can only be shown by the bench's scenarios. These are the exact 62,500-fetch pacing, the counter restarting after an advance, the boundary at 24'h0FFFFF, the single count for a long strobe, the mid-run reset and the independence of LED 0.

// File: rtl/chaser_pkg.sv
package chaser_pkg;
  localparam int unsigned NUM_LEDS = 8;
  localparam int unsigned POS_W    = $clog2(NUM_LEDS);
  typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/fetch_edge.sv
module fetch_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_in,
  output logic fetch_rise
);
  logic m1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m1_q <= 1'b0;
    else        m1_q <= m1_in;
  end

  assign fetch_rise = m1_in & ~m1_q;
endmodule

// File: rtl/step_pacer.sv
module step_pacer #(
  parameter int unsigned LIMIT    = 62500,
  parameter int unsigned PRESC_W  = 24,
  parameter logic [PRESC_W-1:0] SLOW_MIN = 24'h0FFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_rise,
  input  logic [PRESC_W-1:0] prescale,
  output logic               slow_mode,
  output logic               step
);
  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign slow_mode = (prescale >= SLOW_MIN);
  assign step      = fetch_rise & (slow_mode | (cnt == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (step)       cnt <= '0;
    else if (fetch_rise) cnt <= cnt + 1'b1;
  end

  // R4: the counter never reaches its limit
  p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/position_ring.sv
module position_ring
  import chaser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output pos_t pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= pos + 1'b1;
  end
endmodule

// File: rtl/fetch_rate_chaser.sv
module fetch_rate_chaser
  import chaser_pkg::*;
#(
  parameter int unsigned FETCHES_PER_STEP = 62500,
  parameter int unsigned PRESC_W          = 24,
  parameter logic [PRESC_W-1:0] SLOW_MIN  = 24'h0FFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               m1_active,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               boot_ctx,
  output logic [NUM_LEDS-1:0] led
);
  logic fetch_rise;
  logic slow_mode;
  logic step;
  pos_t pos;

  fetch_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .m1_in     (m1_active),
    .fetch_rise(fetch_rise)
  );

  step_pacer #(
    .LIMIT   (FETCHES_PER_STEP),
    .PRESC_W (PRESC_W),
    .SLOW_MIN(SLOW_MIN)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_rise(fetch_rise),
    .prescale  (prescale),
    .slow_mode (slow_mode),
    .step      (step)
  );

  position_ring u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step),
    .pos  (pos)
  );

  assign led[0] = boot_ctx;
  for (genvar k = 1; k < NUM_LEDS; k++) begin : g_point
    assign led[k] = (pos == POS_W'(k));
  end

  // R6: the position holds or steps by exactly one
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == $past(pos)) || (pos == $past(pos) + 1'b1));

  // R6: no movement without a counted fetch
  p_still_without_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_rise |=> $stable(pos));

  // R5: in slow mode every counted fetch moves the point
  p_slow_every_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_rise && slow_mode) |=> (pos == $past(pos) + 1'b1));

  // R7: at most one running-point LED is lit
  p_one_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(led[NUM_LEDS-1:1]));
endmodule

// File: tb/test_fetch_rate_chaser.sv
module test_fetch_rate_chaser;
  localparam int BIG_LIM   = 62500;
  localparam int SMALL_LIM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m1_active = 1'b0;
  logic [23:0] prescale = '0;
  logic        boot_ctx = 1'b0;
  logic [7:0]  led_big, led_small;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int pos_b = 0, cnt_b = 0, pos_s = 0, cnt_s = 0;

  always #4 clk = ~clk;

  fetch_rate_chaser i_fetch_rate_chaser (
    .clk(clk), .rst_n(rst_n), .m1_active(m1_active),
    .prescale(prescale), .boot_ctx(boot_ctx), .led(led_big));

  fetch_rate_chaser #(.FETCHES_PER_STEP(SMALL_LIM)) i_small (
    .clk(clk), .rst_n(rst_n), .m1_active(m1_active),
    .prescale(prescale), .boot_ctx(boot_ctx), .led(led_small));

  // {prescale, fetch count, boot_ctx}
  localparam logic [32:0] VEC [8] = '{
    {24'h000000, 8'd3, 1'b0},
    {24'h000000, 8'd2, 1'b1},
    {24'h0FFFFF, 8'd5, 1'b0},
    {24'hFFFFFF, 8'd9, 1'b1},
    {24'h0FFFFE, 8'd7, 1'b0},
    {24'h100000, 8'd1, 1'b0},
    {24'h000010, 8'd4, 1'b1},
    {24'h7FFFFF, 8'd3, 1'b0}
  };

  function automatic logic [7:0] exp_led(int p, logic c);
    logic [7:0] v = '0;
    v[0] = c;
    if (p != 0) v[p] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_both(string tag);
    check({tag, " big"},   led_big,   exp_led(pos_b, boot_ctx));
    check({tag, " small"}, led_small, exp_led(pos_s, boot_ctx));
  endtask

  task automatic model_fetch();
    bit slow = (prescale >= 24'h0FFFFF);
    cnt_b++; cnt_s++;
    if (slow || cnt_b == BIG_LIM)   begin pos_b = (pos_b + 1) % 8; cnt_b = 0; end
    if (slow || cnt_s == SMALL_LIM) begin pos_s = (pos_s + 1) % 8; cnt_s = 0; end
  endtask

  // one fetch: strobe high for 'hold' cycles, then low for one
  task automatic fetch(int n, int hold = 1);
    for (int i = 0; i < n; i++) begin
      m1_active = 1'b1;
      repeat (hold) @(negedge clk);
      m1_active = 1'b0;
      model_fetch();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pos_b = 0; cnt_b = 0; pos_s = 0; cnt_s = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check_both("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_both("R1 after release");

    // R9: change visible right after the counting edge
    prescale = 24'hFFFFFF;
    m1_active = 1'b1;
    @(posedge clk);
    #1;
    check("R9 big", led_big, exp_led(1, 1'b0));
    @(negedge clk);
    m1_active = 1'b0;
    model_fetch();
    @(negedge clk);
    check_both("R9 R5 settled");
    do_reset();

    // R3: full default group of 62500 fetches
    prescale = 24'h000000;
    fetch(BIG_LIM - 1);
    check_both("R3 one short of group");
    fetch(1);
    check_both("R3 group complete");

    // table walk: R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      prescale = VEC[i][32:9];
      boot_ctx = VEC[i][0];
      fetch(int'(VEC[i][8:1]));
      check_both($sformatf("R3 R4 R5 R6 R7 vector %0d", i));
    end

    // R2: long strobe counts once
    do_reset();
    prescale = 24'h0FFFFF;
    fetch(1, 5);
    check_both("R2 long strobe");

    // R5 boundary: one below threshold is normal mode
    prescale = 24'h0FFFFE;
    fetch(3);
    check_both("R5 below threshold");
    prescale = 24'h0FFFFF;
    fetch(1);
    check_both("R5 at threshold");

    // R4: counter cleared after an advance in normal mode
    prescale = 24'h0;
    fetch(SMALL_LIM);
    fetch(SMALL_LIM - 1);
    check_both("R4 restart count");

    // R8: context flag changes alone
    boot_ctx = 1'b1;
    repeat (3) @(negedge clk);
    check_both("R8 ctx high");
    boot_ctx = 1'b0;
    @(negedge clk);
    check_both("R8 ctx low");

    // R6: wrap 7 -> 0 lights no point
    do_reset();
    prescale = 24'hFFFFFF;
    fetch(7);
    check_both("R6 at seven");
    fetch(1);
    check_both("R6 wrapped to zero");

    // R1: mid-run reset
    fetch(3);
    do_reset();
    check_both("R1 mid-run reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule